// File: doc/BRIEF.md
# Right-Shift Chain with Early Termination

This block is a sequential right shifter. It holds a carry bit, an upper register and a lower register as a single chain. A start pulse loads all three parts. After that, every cycle in which the step input is high shifts the whole chain right by one place. The carry enters the top of the upper register, and the low bit of the upper register enters the top of the lower register. A count of the remaining shifts starts at the width of the lower register and drops by one on each shift.

A run ends in one of two ways:
- The remaining count reaches zero. The result is then the upper and lower registers side by side.
- The lower register becomes all zeros after at least one shift. The run then stops at once. The result is the upper register widened with zeros and moved left by the number of shifts done so far.

The two endings give the same value that the full run would have produced, but an early run takes fewer step cycles. The block suits a shift-and-add datapath whose multiplier operand runs out of set bits early.

When a run ends, the result is written to a register and a one-cycle done pulse is raised. There is no backpressure on the result.

Top module: `rshift_early_exit`

## Requirements
- R1: After reset, `done_o` and `busy_o` are 0 and `res_o` is all zeros.
- R2: A high `start_i` while idle loads `carry_i`, `hi_i` and `lo_i`. `busy_o` is 1 from the next cycle until the run ends.
- R3: While busy, each cycle with `step_i` high performs exactly one right shift of the chain {carry, upper, lower}. A zero enters the carry position. A cycle with `step_i` low changes neither the state nor the outputs.
- R4: If the lower register never becomes zero, the run ends after QW shifts. `res_o` is then {upper, lower} as they stand after the last shift.
- R5: If the lower register becomes zero after s shifts, with 1 ≤ s < QW, the run ends after that shift. `res_o` is then the upper register, zero-extended to AW+QW bits and shifted left by s. This value equals the result of the full QW-shift run.
- R6: The zero test on the lower register is made only after a shift. Loading a lower value of zero therefore still takes at least one step, and the carry bit appears in the result.
- R7: `done_o` is high for exactly one cycle, the cycle after the final shift. In that same cycle `busy_o` is low and `res_o` holds the new result.
- R8: `start_i` has no effect while busy. The run in progress completes with the result of its own loaded operands.
- R9: `res_o` keeps its value from one completion until the next.
- R10: The number of step cycles in a run equals the smallest s ≥ 1 for which the lower register is zero after s shifts, or QW if there is no such s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load the operands and begin a run (honoured only while idle) |
| step_i | input | 1 | Shift enable for the current cycle |
| carry_i | input | 1 | Initial carry bit |
| hi_i | input | AW | Initial upper register |
| lo_i | input | QW | Initial lower register |
| res_o | output | AW+QW | Registered result of the last completed run |
| done_o | output | 1 | One-cycle pulse: the run has finished |
| busy_o | output | 1 | A run is in progress |

## Verification
A fault in the chain or the shift counter shows up on `res_o` in the first done pulse after it occurs. The bench compares every result against a model that always performs all QW shifts, so an early-exit composition that is off by one place cannot go unnoticed. A wrong count or a wrong zero test moves the done pulse to a different step cycle. This is visible after a single run, because the bench counts step cycles and compares them with the first shift at which the lower register is zero. A zero test made before the first shift shows at once in the case of a loaded lower value of zero with the carry set.

// File: rtl/rse_pkg.sv
package rse_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } rse_phase_e;
endpackage

// File: rtl/rse_chain.sv
module rse_chain #(
    parameter int AW = 8,
    parameter int QW = 8
) (
    input  logic          c_i,
    input  logic [AW-1:0] a_i,
    input  logic [QW-1:0] q_i,
    output logic          c_o,
    output logic [AW-1:0] a_o,
    output logic [QW-1:0] q_o,
    output logic          q_zero_o
);
    localparam int CHW = 1 + AW + QW;

    logic [CHW-1:0] chain_cur;
    logic [CHW-1:0] chain_nxt;

    always_comb begin
        chain_cur = {c_i, a_i, q_i};
        chain_nxt = chain_cur >> 1;
        c_o       = chain_nxt[CHW-1];
        a_o       = chain_nxt[QW +: AW];
        q_o       = chain_nxt[QW-1:0];
        q_zero_o  = ~|chain_nxt[QW-1:0];
    end
endmodule

// File: rtl/rse_compose.sv
module rse_compose #(
    parameter int AW   = 8,
    parameter int QW   = 8,
    parameter int CNTW = 4
) (
    input  logic [AW-1:0]    a_i,
    input  logic [QW-1:0]    q_i,
    input  logic [CNTW-1:0]  shifts_i,
    input  logic             early_i,
    output logic [AW+QW-1:0] res_o
);
    localparam int RW = AW + QW;

    logic [RW-1:0] widened;

    always_comb begin
        widened = {{QW{1'b0}}, a_i};
        if (early_i) begin
            res_o = widened << shifts_i;
        end else begin
            res_o = {a_i, q_i};
        end
    end
endmodule

// File: rtl/rshift_early_exit.sv
module rshift_early_exit #(
    parameter int AW = 8,
    parameter int QW = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             carry_i,
    input  logic [AW-1:0]    hi_i,
    input  logic [QW-1:0]    lo_i,
    output logic [AW+QW-1:0] res_o,
    output logic             done_o,
    output logic             busy_o
);
    import rse_pkg::*;

    localparam int RW   = AW + QW;
    localparam int CNTW = $clog2(QW + 1);

    typedef struct packed {
        rse_phase_e      phase;
        logic            done;
        logic [CNTW-1:0] left;
        logic            c;
        logic [AW-1:0]   a;
        logic [QW-1:0]   q;
        logic [RW-1:0]   res;
    } rse_state_t;

    rse_state_t st_d, st_q;

    logic            c_sh;
    logic [AW-1:0]   a_sh;
    logic [QW-1:0]   q_sh;
    logic            q_zero_sh;
    logic [CNTW-1:0] left_dec;
    logic [CNTW-1:0] shifts_done;
    logic            early_end;
    logic [RW-1:0]   res_build;

    rse_chain #(.AW(AW), .QW(QW)) u_chain (
        .c_i      (st_q.c),
        .a_i      (st_q.a),
        .q_i      (st_q.q),
        .c_o      (c_sh),
        .a_o      (a_sh),
        .q_o      (q_sh),
        .q_zero_o (q_zero_sh)
    );

    always_comb begin
        left_dec    = st_q.left - CNTW'(1);
        shifts_done = CNTW'(QW) - left_dec;
        early_end   = (left_dec != '0);
    end

    rse_compose #(.AW(AW), .QW(QW), .CNTW(CNTW)) u_compose (
        .a_i      (a_sh),
        .q_i      (q_sh),
        .shifts_i (shifts_done),
        .early_i  (early_end),
        .res_o    (res_build)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.left  = CNTW'(QW);
                    st_d.c     = carry_i;
                    st_d.a     = hi_i;
                    st_d.q     = lo_i;
                end
            end
            PH_RUN: begin
                if (step_i) begin
                    st_d.c    = c_sh;
                    st_d.a    = a_sh;
                    st_d.q    = q_sh;
                    st_d.left = left_dec;
                    if ((left_dec == '0) || q_zero_sh) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                        st_d.res   = res_build;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0, left: '0, c: 1'b0,
                      a: '0, q: '0, res: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o  = st_q.res;
    assign done_o = st_q.done;
    assign busy_o = (st_q.phase == PH_RUN);
endmodule

// File: rtl/rse_checker.sv
module rse_checker #(
    parameter int AW = 8,
    parameter int QW = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             step_i,
    input logic [AW+QW-1:0] res_o,
    input logic             done_o,
    input logic             busy_o
);
    localparam int CW = $clog2(QW + 2);

    logic [CW-1:0] steps_seen;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            steps_seen <= '0;
        end else if (!busy_o && start_i) begin
            steps_seen <= '0;
        end else if (busy_o && step_i) begin
            steps_seen <= steps_seen + CW'(1);
        end
    end

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!done_o && !busy_o && res_o == '0));

    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    p_hold_no_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !step_i) |=> (busy_o && !done_o));

    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    p_res_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(res_o));

    p_step_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (steps_seen >= CW'(1) && steps_seen <= CW'(QW)));
endmodule

bind rshift_early_exit rse_checker #(.AW(AW), .QW(QW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .step_i  (step_i),
    .res_o   (res_o),
    .done_o  (done_o),
    .busy_o  (busy_o)
);

// File: tb/rshift_early_exit_tb.sv
module rshift_early_exit_tb;
    localparam int AW = 8;
    localparam int QW = 8;
    localparam int RW = AW + QW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          step = 1'b0;
    logic          carry = 1'b0;
    logic [AW-1:0] hi = '0;
    logic [QW-1:0] lo = '0;
    logic [RW-1:0] res;
    logic          done;
    logic          busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rshift_early_exit #(.AW(AW), .QW(QW)) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .step_i  (step),
        .carry_i (carry),
        .hi_i    (hi),
        .lo_i    (lo),
        .res_o   (res),
        .done_o  (done),
        .busy_o  (busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: always performs all QW shifts; step count is the first
    // shift after which the lower part is zero, else QW.
    function automatic logic [RW-1:0] ref_result(input logic c, input logic [AW-1:0] a,
                                                  input logic [QW-1:0] q);
        logic [RW:0] ch;
        ch = {c, a, q};
        for (int s = 0; s < QW; s++) ch = ch >> 1;
        return ch[RW-1:0];
    endfunction

    function automatic int ref_steps(input logic c, input logic [AW-1:0] a,
                                     input logic [QW-1:0] q);
        logic [RW:0] ch;
        ch = {c, a, q};
        for (int s = 1; s <= QW; s++) begin
            ch = ch >> 1;
            if (ch[QW-1:0] == '0) return s;
        end
        return QW;
    endfunction

    // Runs one operation. gap: idle step cycles between steps.
    // poke: pulse start with other operands during the run.
    task automatic run_op(input logic c, input logic [AW-1:0] a, input logic [QW-1:0] q,
                          input int gap, input bit poke, input string tag);
        int n;
        logic [RW-1:0] exp_res;
        int exp_n;
        exp_res = ref_result(c, a, q);
        exp_n   = ref_steps(c, a, q);
        n = 0;
        @(negedge clk);
        start = 1'b1; carry = c; hi = a; lo = q;
        @(negedge clk);
        start = 1'b0; carry = ~c; hi = ~a; lo = ~q;
        chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
        for (int k = 0; k < 4 * QW; k++) begin
            for (int g = 0; g < gap; g++) begin
                step = 1'b0;
                @(negedge clk);
                chk(busy && !done, "R3 no progress without step", 32'(done), 0);
            end
            step = 1'b1;
            if (poke) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
            if (done) break;
        end
        step = 1'b0;
        chk(done == 1'b1, {tag, " R7 done seen"}, 32'(done), 1);
        chk(busy == 1'b0, {tag, " R7 idle at done"}, 32'(busy), 0);
        chk(n == exp_n, {tag, " R10 step count"}, 32'(n), 32'(exp_n));
        chk(res == exp_res, {tag, " result"}, 32'(res), 32'(exp_res));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R7 single pulse"}, 32'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1 flags", 32'({done, busy}), 0);
        chk(res == '0, "R1 result", 32'(res), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_full_run();
        run_op(1'b1, 8'hFF, 8'hFF, 0, 1'b0, "R4 full");
        chk(res == 16'h01FF, "R4 literal", 32'(res), 32'h01FF);
    endtask

    task automatic t_early_example();
        run_op(1'b0, 8'hD4, 8'h03, 0, 1'b0, "R5 early");
        chk(res == 16'h00D4, "R5 literal", 32'(res), 32'h00D4);
    endtask

    task automatic t_zero_first();
        run_op(1'b1, 8'h00, 8'h00, 0, 1'b0, "R6 zero lo");
        chk(res == 16'h0100, "R6 carry kept", 32'(res), 32'h0100);
    endtask

    task automatic t_gaps();
        run_op(1'b0, 8'h5A, 8'h30, 2, 1'b0, "R3 gaps");
    endtask

    task automatic t_start_busy();
        run_op(1'b1, 8'h81, 8'h44, 1, 1'b1, "R8 start ignored");
    endtask

    task automatic t_hold();
        logic [RW-1:0] keep;
        keep = res;
        repeat (5) @(negedge clk);
        chk(res == keep && !done, "R9 result held", 32'(res), 32'(keep));
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            logic [QW-1:0] q;
            a = AW'($urandom);
            q = QW'($urandom);
            if (i % 3 == 0) q = q & 8'h0F;
            run_op(1'b0, a, q, i % 2, 1'b0, "R5 random");
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_full_run();
        t_early_example();
        t_zero_first();
        t_gaps();
        t_start_busy();
        t_hold();
        t_random();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule